// File: doc/BRIEF.md
# Byte-Wide Bidirectional I/O Port

This block is one general-purpose I/O port of eight pads. Software reaches it over a small register bus with a 2-bit address, a write enable and a byte of write data. Reads return a byte with no wait state. Three registers control the port: a direction byte, a data byte and a pin byte that software can only read. Each pad has its own direction bit. A bit set to 1 makes that pad an output, and a bit cleared to 0 makes it an input.

The data byte has two meanings, and the direction bit of the same position decides which one applies. For an output pad the data bit is the level driven onto the pad. For an input pad the same bit turns the pad's pull-up on (1) or leaves the pad floating (0). The pin byte always shows the level actually present on each pad, not the data byte. The pad input passes through a two-flop synchronizer before it can be read. This means an output pad's own driven value also shows up in the pin byte only after that synchronizer delay.

Top module: `gpio8_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction and data bytes are zero. All pads are floating inputs: padOe, padOut and padPullEn are all zero.
- R2: A write with address 1 loads the direction byte at the next rising clock edge. padOe equals the direction byte, and a read of address 1 returns it.
- R3: A write with address 2 loads the data byte at the next rising clock edge. A read of address 2 returns the data byte whatever the direction bits are.
- R4: For every bit, padOut is the data bit when the direction bit is 1, and 0 when the direction bit is 0.
- R5: For every bit, padPullEn is the data bit when the direction bit is 0, and 0 when the direction bit is 1.
- R6: A read of address 0 returns padIn as it was sampled two rising clock edges earlier. An output pad therefore reads back its driven level through the same path.
- R7: A write with address 0 is ignored. The direction byte, the data byte and all pad outputs keep their values.
- R8: A read of address 3 returns zero, and a write to address 3 changes no state.
- R9: When wrEn is low, no register changes, whatever the values of addr and wrData.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register bus |
| addr | input | 2 | Register select: 0 pin, 1 direction, 2 data, 3 unused |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data for the selected register, combinational |
| padIn | input | 8 | Level present on each pad |
| padOe | output | 8 | Per-pad output enable |
| padOut | output | 8 | Per-pad driven level |
| padPullEn | output | 8 | Per-pad pull-up enable |

## Verification
A corrupted direction bit shows up on padOe at the same position in the cycle after the write. Because the data byte's meaning is swapped at that position, the same fault also moves the bit between padOut and padPullEn. A wrong data bit shows up at once on whichever of those two outputs is active, and on a read of address 2. A fault in the synchronizer is only visible through reads of address 0. It appears two cycles after a pad level changes, so the bench follows every pad change with a pin read at the right offset. An address decode fault shows up as a changed register after a write to address 0 or 3, or as a nonzero read of address 3.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_DATA = 2'd2;

  typedef struct packed {
    logic loadDir;
    logic loadData;
    logic readPin;
    logic readDir;
    logic readData;
  } portStrobe_t;
endpackage

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
  import gpio8_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strobe
);
  logic hitPin, hitDir, hitData;

  always_comb begin
    hitPin  = (addr == SEL_PIN);
    hitDir  = (addr == SEL_DIR);
    hitData = (addr == SEL_DATA);
    strobe.readPin  = hitPin;
    strobe.readDir  = hitDir;
    strobe.readData = hitData;
    // the pin byte takes no writes; an unused address decodes to nothing
    strobe.loadDir  = wrEn & hitDir;
    strobe.loadData = wrEn & hitData;
  end
endmodule

// File: rtl/gpio8_datapath.sv
module gpio8_datapath
  import gpio8_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn,
  output logic [WIDTH-1:0] rdData
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] syncChain [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.loadDir)  dirReg  <= wrData;
      if (strobe.loadData) dataReg <= wrData;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  // per-bit pad drive: the data bit is steered by its direction bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_pad
    always_comb begin
      padOe[b]     = dirReg[b];
      padOut[b]    = dirReg[b]  ? dataReg[b] : 1'b0;
      padPullEn[b] = !dirReg[b] ? dataReg[b] : 1'b0;
    end
  end

  always_comb begin
    rdData = ({WIDTH{strobe.readPin}}  & syncChain[LAST])
           | ({WIDTH{strobe.readDir}}  & dirReg)
           | ({WIDTH{strobe.readData}} & dataReg);
  end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
  import gpio8_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);
  portStrobe_t strobe;

  gpio8_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio8_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullEn (padPullEn),
    .rdData    (rdData)
  );
endmodule

// File: rtl/gpio8_checker.sv
module gpio8_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padPullEn
);
  logic [1:0] upCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               upCycles <= '0;
    else if (upCycles != 2'd3) upCycles <= upCycles + 2'd1;
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1) |=> (padOe == $past(wrData)));

  a_r3_data_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2) |=> ((padOut | padPullEn) == $past(wrData)));

  a_r4_out_only_when_driven: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut & ~padOe) == '0));

  a_r5_pull_only_on_inputs: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullEn & padOe) == '0));

  a_r6_pin_delay: assert property (@(posedge clk) disable iff (!rstN)
    (upCycles >= 2'd2 && addr == 2'd0) |-> (rdData == $past(padIn, 2)));

  a_r7_pin_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> ($stable(padOe) && $stable(padOut) && $stable(padPullEn)));

  a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd3) |-> (rdData == '0));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> ($stable(padOe) && $stable(padOut) && $stable(padPullEn)));
endmodule

bind gpio8_port gpio8_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .padIn     (padIn),
  .padOe     (padOe),
  .padOut    (padOut),
  .padPullEn (padPullEn)
);

// File: tb/tb_gpio8_port.sv
`timescale 1ns/1ps
module tb_gpio8_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, padIn, padOe, padOut, padPullEn;
  logic [7:0] extVal = 8'h00;
  logic [7:0] extEn  = 8'h00;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mDir = 8'h00, mData = 8'h00;
  logic [7:0] h1, h2;

  always #10 clk = ~clk;

  // pad model: driven pads read their own level, external source beats pull-up
  always_comb begin
    for (int b = 0; b < 8; b++)
      padIn[b] = padOe[b] ? padOut[b] : (extEn[b] ? extVal[b] : padPullEn[b]);
  end

  // expected pin byte: pad level two rising edges back
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin h1 <= 8'h00; h2 <= 8'h00; end
    else begin h1 <= padIn; h2 <= h1; end
  end

  gpio8_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .padPullEn(padPullEn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return h2;
      2'd1: return mDir;
      2'd2: return mData;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chkPads(input string req);
    chk({req, " padOe"}, padOe, mDir);
    chk({req, " padOut"}, padOut, mData & mDir);
    chk({req, " padPullEn"}, padPullEn, mData & ~mDir);
  endtask

  // called right after a negedge; returns right after the next negedge
  task automatic busCycle(input logic we, input logic [1:0] a, input logic [7:0] d);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    if (we && a == 2'd1) mDir = d;
    if (we && a == 2'd2) mData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic readReg(input string req, input logic [1:0] a);
    addr = a; #1;
    chk(req, rdData, expRead(a));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    // R1 during reset
    chkPads("R1 in reset");
    rstN = 1'b1;
    @(negedge clk); #1;
    chkPads("R1 after reset");
    readReg("R1 dir read", 2'd1);
    readReg("R1 data read", 2'd2);
    readReg("R1 pin read", 2'd0);

    // R2 / R3 / R4 / R5 mixed direction
    busCycle(1'b1, 2'd1, 8'h0F);
    chk("R2 padOe", padOe, 8'h0F);
    busCycle(1'b1, 2'd2, 8'h3C);
    chk("R4 padOut", padOut, 8'h0C);
    chk("R5 padPullEn", padPullEn, 8'h30);
    readReg("R2 dir read", 2'd1);
    readReg("R3 data read", 2'd2);

    // R6 pin path timing with an external source on the inputs
    extEn = 8'hF0; extVal = 8'hA0;
    busCycle(1'b0, 2'd0, 8'h00);
    busCycle(1'b0, 2'd0, 8'h00);
    busCycle(1'b0, 2'd0, 8'h00);
    readReg("R6 steady pin", 2'd0);
    chk("R6 steady pin value", rdData, 8'hAC);
    extVal = 8'h50;
    busCycle(1'b0, 2'd0, 8'h00);
    chk("R6 one edge later still old", rdData, 8'hAC);
    busCycle(1'b0, 2'd0, 8'h00);
    chk("R6 two edges later new", rdData, 8'h5C);

    // R7 write to pin byte ignored
    busCycle(1'b1, 2'd0, 8'hFF);
    chkPads("R7 pin write");
    readReg("R7 dir kept", 2'd1);
    readReg("R7 data kept", 2'd2);

    // R8 unused address
    busCycle(1'b1, 2'd3, 8'hFF);
    chkPads("R8 write addr3");
    readReg("R8 read addr3", 2'd3);
    chk("R8 read addr3 zero", rdData, 8'h00);

    // R9 no write without strobe
    busCycle(1'b0, 2'd1, 8'hAA);
    busCycle(1'b0, 2'd2, 8'h55);
    chkPads("R9 idle");
    readReg("R9 dir kept", 2'd1);

    // random mix, all requirements R2..R9
    for (int i = 0; i < 400; i++) begin
      logic       we;
      logic [1:0] a;
      logic [7:0] d;
      we = 1'($urandom);
      a  = 2'($urandom);
      d  = 8'($urandom);
      extVal = 8'($urandom);
      extEn  = 8'($urandom);
      addr = a; #1;
      chk("R6 R8 random read", rdData, expRead(a));
      busCycle(we, a, d);
      chkPads("R2 R3 R4 R5 R7 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule